// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block produces the answer a card gives when its reset line is sampled high on a serial clock pulse. The serial clock and the card reset pin come in as ordinary inputs. Both are synchronised into the system clock domain, and each rising edge of the serial clock counts as one pulse. When a pulse finds the reset pin high, the block loads a fixed 32-bit answer, set as a parameter. It takes the data line and emits a one-cycle strobe that tells the rest of the card to drop every password and authentication privilege it has granted.

After the reset pin is released, each further pulse moves the line to the next answer bit. Bits go out least significant bit first, starting with byte 0 and ending with byte 3. The 32nd pulse releases the line and hands the card back to normal command decoding. A new reset seen during the answer starts it again from bit 0.

Top module: `atr_shifter`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the block is idle: `sda_oe`=0, `sda_out`=1, `cmd_mode`=1 and `priv_clr`=0. Pulling `rst_n` low during an answer aborts that answer.
- R2: A rising edge of `ser_clk` with `card_rst` high makes the block drive the line: `sda_oe`=1, `cmd_mode`=0, and `sda_out` equals bit 0 of `ANSWER`.
- R3: Every rising edge of `ser_clk` that sees `card_rst` high gives exactly one `priv_clr` pulse, one system clock long. No other event produces `priv_clr`.
- R4: `card_rst` high with no rising edge on `ser_clk` has no effect. The block stays idle and `priv_clr` stays low.
- R5: With `card_rst` low, after k pulses (0 ≤ k < 32) following the reset, `sda_out` equals `ANSWER[k]`. This is bit k%8 of byte k/8, with byte n held in `ANSWER[8n+7:8n]`.
- R6: The 32nd pulse after the reset clears `sda_oe`, sets `cmd_mode` and returns `sda_out` to 1.
- R7: A pulse with `card_rst` high in the middle of an answer restarts it at bit 0, and the 32-pulse count starts again.
- R8: Pulses with `card_rst` low while idle leave the block idle.
- R9: While `card_rst` stays high over several pulses, the line holds bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low chip reset, asynchronous |
| ser_clk | input | 1 | Serial clock from the reader, asynchronous to `clk` |
| card_rst | input | 1 | Card reset pin, sampled on serial clock pulses |
| sda_out | output | 1 | Serial data value; 1 when not driving |
| sda_oe | output | 1 | Data line output enable |
| priv_clr | output | 1 | One-cycle strobe that revokes all granted privileges |
| cmd_mode | output | 1 | High when the card is back in command mode |

## Verification
The assertions assume that each `ser_clk` level lasts longer than the synchroniser depth plus one system clock. Under that assumption every edge is seen exactly once and `priv_clr` can never be asked for on two cycles in a row. They also assume that `card_rst` is stable around each rising edge of `ser_clk`. The stimulus holds each serial clock phase for four system clocks and changes `card_rst` only while `ser_clk` is low.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [0:0] {
        ATR_IDLE = 1'b0,
        ATR_SEND = 1'b1
    } atr_state_e;

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/atr_pulse_det.sv
module atr_pulse_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d;
    logic prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/atr_bit_sel.sv
module atr_bit_sel #(
    parameter int          BYTES  = 4,
    parameter int          BYTE_W = 8,
    parameter logic [BYTES*BYTE_W-1:0] ANSWER = '0,
    localparam int         BIT_W  = $clog2(BYTE_W),
    localparam int         SEL_W  = $clog2(BYTES),
    localparam int         IDX_W  = SEL_W + BIT_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    logic [BYTE_W-1:0] byte_arr [BYTES];
    logic [SEL_W-1:0]  byte_sel;
    logic [BIT_W-1:0]  bit_sel;

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_byte
            assign byte_arr[g] = ANSWER[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        byte_sel = idx[IDX_W-1:BIT_W];
        bit_sel  = idx[BIT_W-1:0];
        bit_o    = byte_arr[byte_sel][bit_sel];
    end
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
    import atr_pkg::*;
#(
    parameter int  BITS  = 32,
    localparam int IDX_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             rst_lvl,
    output atr_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             clr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

    typedef struct packed {
        atr_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             clr;
    } ctrl_t;

    ctrl_t s_d;
    ctrl_t s_q;

    always_comb begin
        s_d     = s_q;
        s_d.clr = 1'b0;
        if (pulse) begin
            if (rst_lvl) begin
                s_d.state = ATR_SEND;
                s_d.idx   = '0;
                s_d.clr   = 1'b1;
            end else if (s_q.state == ATR_SEND) begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.state = ATR_IDLE;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ATR_IDLE, idx: '0, clr: 1'b0};
        else        s_q <= s_d;
    end

    assign state = s_q.state;
    assign idx   = s_q.idx;
    assign clr   = s_q.clr;
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
    import atr_pkg::*;
#(
    parameter int    BYTES       = 4,
    parameter int    BYTE_W      = 8,
    parameter int    SYNC_STAGES = 2,
    parameter logic [BYTES*BYTE_W-1:0] ANSWER = 32'h9A30_7D2C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic card_rst,
    output logic sda_out,
    output logic sda_oe,
    output logic priv_clr,
    output logic cmd_mode
);
    localparam int BITS  = BYTES * BYTE_W;
    localparam int IDX_W = $clog2(BITS);

    logic             sclk_s;
    logic             crst_s;
    logic             pulse;
    atr_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             cur_bit;

    atr_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s)
    );

    atr_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .d(card_rst), .q(crst_s)
    );

    atr_pulse_det u_edge (
        .clk(clk), .rst_n(rst_n), .level(sclk_s), .rise(pulse)
    );

    atr_ctrl #(.BITS(BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pulse(pulse), .rst_lvl(crst_s),
        .state(state), .idx(idx), .clr(priv_clr)
    );

    atr_bit_sel #(.BYTES(BYTES), .BYTE_W(BYTE_W), .ANSWER(ANSWER)) u_sel (
        .idx(idx), .bit_o(cur_bit)
    );

    always_comb begin
        sda_oe   = (state == ATR_SEND);
        cmd_mode = (state == ATR_IDLE);
        sda_out  = sda_oe ? cur_bit : 1'b1;
    end
endmodule

// File: rtl/atr_shifter_chk.sv
module atr_shifter_chk #(
    parameter int BITS = 32,
    parameter logic [BITS-1:0] ANSWER = '0
) (
    input logic clk,
    input logic rst_n,
    input logic sda_out,
    input logic sda_oe,
    input logic priv_clr,
    input logic cmd_mode
);
    // R3
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_clr |=> !priv_clr);

    // R2
    clr_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_clr |-> (sda_oe && !cmd_mode));

    // R7
    restart_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_clr |-> (sda_out == ANSWER[0]));

    // R8
    entry_only_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> priv_clr);

    // R6
    released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> (sda_out && cmd_mode));
endmodule

bind atr_shifter atr_shifter_chk #(.BITS(BYTES*BYTE_W), .ANSWER(ANSWER)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_out(sda_out), .sda_oe(sda_oe),
    .priv_clr(priv_clr), .cmd_mode(cmd_mode)
);

// File: tb/atr_shifter_tb.sv
module atr_shifter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ANS = 32'h9A30_7D2C;

    typedef struct {
        logic  oe;
        logic  dout;
        logic  cmd;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic card_rst = 1'b0;
    logic sda_out, sda_oe, priv_clr, cmd_mode;

    exp_t exp_q[$];
    event sample_ev;
    int   vectors = 0;
    int   fails = 0;
    int   exp_clr = 0;
    int   seen_clr = 0;
    int   clr_run = 0;
    bit   done = 1'b0;

    bit   m_act = 1'b0;
    int   m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .card_rst(card_rst),
        .sda_out(sda_out), .sda_oe(sda_oe), .priv_clr(priv_clr), .cmd_mode(cmd_mode)
    );

    // monitor: pops expectations and compares
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (sda_oe !== e.oe || sda_out !== e.dout || cmd_mode !== e.cmd) begin
                    fails++;
                    $display("FAIL %s: got oe=%b out=%b cmd=%b expected oe=%b out=%b cmd=%b",
                             e.tag, sda_oe, sda_out, cmd_mode, e.oe, e.dout, e.cmd);
                end
            end
        end
    end

    // R3: pulse width and count of privilege-clear
    always @(negedge clk) begin
        if (priv_clr === 1'b1) begin
            clr_run++;
            if (clr_run == 1) seen_clr++;
            if (clr_run == 2) begin
                fails++;
                $display("FAIL R3: priv_clr high %0d cycles, expected 1", clr_run);
            end
        end else begin
            clr_run = 0;
        end
    end

    task automatic expect_now(string tag);
        exp_t e;
        e.oe   = m_act;
        e.dout = m_act ? ANS[m_idx] : 1'b1;
        e.cmd  = !m_act;
        e.tag  = tag;
        exp_q.push_back(e);
        -> sample_ev;
        @(negedge clk);
    endtask

    task automatic pulse(logic rlev, string tag);
        @(negedge clk);
        card_rst = rlev;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        if (rlev) begin
            m_act = 1'b1; m_idx = 0; exp_clr++;
        end else if (m_act) begin
            if (m_idx == 31) begin m_act = 1'b0; m_idx = 0; end
            else m_idx++;
        end
        expect_now(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now("R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_now("R1 after reset");

        card_rst = 1'b1;
        repeat (12) @(negedge clk);
        expect_now("R4 reset pin without clock");
        card_rst = 1'b0;
        repeat (4) @(negedge clk);

        pulse(1'b0, "R8 idle pulse");
        pulse(1'b0, "R8 idle pulse 2");

        pulse(1'b1, "R2 reset detected");
        pulse(1'b1, "R9 reset held");
        for (int k = 0; k < 32; k++) pulse(1'b0, (k < 31) ? "R5 answer bit" : "R6 release");
        pulse(1'b0, "R8 pulse after release");

        pulse(1'b1, "R2 second reset");
        for (int k = 0; k < 10; k++) pulse(1'b0, "R5 answer bit");
        pulse(1'b1, "R7 restart");
        for (int k = 0; k < 32; k++) pulse(1'b0, (k < 31) ? "R7 after restart" : "R6 release after restart");

        pulse(1'b1, "R2 third reset");
        for (int k = 0; k < 5; k++) pulse(1'b0, "R5 answer bit");
        @(negedge clk);
        rst_n = 1'b0;
        m_act = 1'b0; m_idx = 0;
        repeat (2) @(negedge clk);
        expect_now("R1 abort by chip reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        vectors++;
        if (seen_clr != exp_clr) begin
            fails++;
            $display("FAIL R3: priv_clr pulses %0d expected %0d", seen_clr, exp_clr);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run hung, got no end expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule